// File: doc/BRIEF.md
# Fused Convolution and Max-Pooling Engine

The engine computes one output tile of a small convolutional layer. On a start pulse it walks a multichannel square image held in a word-addressed memory, applies a separate square kernel to every channel and sums the per-channel results into a partial-sum map kept inside the block. The map is then reduced by non-overlapping max pooling with a zero floor, and the pooled words are written to an output memory port.

The engine does not make a second pass over the finished map. Pooling runs while the last channel is being convolved. Each pooling window is emitted as soon as its bottom-right partial sum receives its final contribution. The image and weight memories are read through request strobes and answer one cycle later. The defaults are 16 channels, an 8x8 image, a 3x3 kernel and 2x2 pooling, which gives a 6x6 map and a 3x3 result.

Top module: `conv_pool_engine`

## Requirements
- R1: While reset is held and after its release without a start, busy_o, done_o, out_we_o, img_rd_o and wgt_rd_o are all low.
- R2: Image word (c, y, x) is read from address 64*c + 8*y + x. The data is taken in the cycle after the img_rd_o strobe. A run issues exactly 16*36*9 = 5184 image reads, and every read stays below 1024.
- R3: Weight word (c, ky, kx) is read from address 9*c + 3*ky + kx, with the same one-cycle latency. A run issues exactly 144 weight reads, and every read stays below 144.
- R4: Map element (oy, ox) equals the sum over all channels, ky and kx of pixel (c, oy+ky, ox+kx) times weight (c, ky, kx). The convolution is valid, has stride 1 and uses no padding.
- R5: Each pooled word is the signed maximum of zero and the four map elements of its 2x2 window at stride 2, so an all-negative window yields 0.
- R6: Exactly nine writes occur per run, in row-major pooled order, to addresses 0 through 8, and only while busy_o is high.
- R7: Pooled words are written while the final channel is still being read. The first write follows at least one final-channel image read, and more final-channel reads come after it.
- R8: done_o is a one-cycle pulse in the cycle after the write to address 8. busy_o is low in the following cycle.
- R9: A start pulse while busy_o is high is ignored. The run keeps its length and its results.
- R10: Products and sums are 32 bits wide and wrap in two's complement on overflow.
- R11: The partial-sum map is cleared at every accepted start, so back-to-back runs give results that do not depend on earlier runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when the block is idle |
| busy_o | output | 1 | High from an accepted start until the cycle after done |
| done_o | output | 1 | One-cycle pulse after the last pooled write |
| img_rd_o | output | 1 | Image read request |
| img_addr_o | output | 10 | Image word address |
| img_data_i | input | 32 | Image word, valid one cycle after the request |
| wgt_rd_o | output | 1 | Weight read request |
| wgt_addr_o | output | 8 | Weight word address |
| wgt_data_i | input | 32 | Weight word, valid one cycle after the request |
| out_we_o | output | 1 | Output write strobe |
| out_addr_o | output | 4 | Output word address |
| out_data_o | output | 32 | Pooled output word |

## Verification
Uniform ones give 144 everywhere, which shows whether every channel and every tap is counted. A ramped image with cycling weights separates row from column and catches kernel flips or a wrong channel stride. A single-channel horizontal ramp with a centre-only kernel gives windows that are negative, zero and positive, and a uniformly negative case checks the zero floor. A near-full-scale case checks wrap-around. Pseudo-random signed data is run twice, the first time with a stray start in mid-run, which tests that start is ignored and that the map is cleared between runs.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WLD, ST_CONV, ST_WAIT} cpe_state_e;

  function automatic int wbits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cpe_ctrl.sv
module cpe_ctrl #(
  parameter int CH  = 16,
  parameter int IMG = 8,
  parameter int KS  = 3,
  localparam int OUT   = IMG - KS + 1,
  localparam int NT    = KS * KS,
  localparam int CH_W  = cpe_pkg::wbits(CH),
  localparam int K_W   = cpe_pkg::wbits(KS),
  localparam int OUT_W = cpe_pkg::wbits(OUT),
  localparam int TAP_W = cpe_pkg::wbits(NT),
  localparam int IA_W  = cpe_pkg::wbits(CH * IMG * IMG),
  localparam int WA_W  = cpe_pkg::wbits(CH * NT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fin_i,
  output logic             busy_o,
  output logic             clr_o,
  output logic             wld_o,
  output logic [TAP_W-1:0] widx_o,
  output logic [WA_W-1:0]  wgt_addr_o,
  output logic             img_rd_o,
  output logic [IA_W-1:0]  img_addr_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             first_o,
  output logic             last_o,
  output logic [OUT_W-1:0] oy_o,
  output logic [OUT_W-1:0] ox_o,
  output logic             lch_o
);
  import cpe_pkg::*;

  cpe_state_e       state_q;
  logic [CH_W-1:0]  ch_q;
  logic [OUT_W-1:0] oy_q, ox_q;
  logic [K_W-1:0]   ky_q, kx_q;
  logic             kx_end, ky_end, ox_end, oy_end, ch_end;
  logic [TAP_W-1:0] tap;

  assign kx_end = kx_q == K_W'(KS - 1);
  assign ky_end = ky_q == K_W'(KS - 1);
  assign ox_end = ox_q == OUT_W'(OUT - 1);
  assign oy_end = oy_q == OUT_W'(OUT - 1);
  assign ch_end = ch_q == CH_W'(CH - 1);
  assign tap    = TAP_W'(int'(ky_q) * KS + int'(kx_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      oy_q    <= '0;
      ox_q    <= '0;
      ky_q    <= '0;
      kx_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WLD;
          ch_q    <= '0;
          ky_q    <= '0;
          kx_q    <= '0;
        end
        ST_WLD: begin
          if (kx_end) begin
            kx_q <= '0;
            if (ky_end) begin
              ky_q    <= '0;
              oy_q    <= '0;
              ox_q    <= '0;
              state_q <= ST_CONV;
            end else ky_q <= ky_q + 1'b1;
          end else kx_q <= kx_q + 1'b1;
        end
        ST_CONV: begin
          if (kx_end) begin
            kx_q <= '0;
            if (ky_end) begin
              ky_q <= '0;
              if (ox_end) begin
                ox_q <= '0;
                if (oy_end) begin
                  oy_q <= '0;
                  if (ch_end) state_q <= ST_WAIT;
                  else begin
                    ch_q    <= ch_q + 1'b1;
                    state_q <= ST_WLD;
                  end
                end else oy_q <= oy_q + 1'b1;
              end else ox_q <= ox_q + 1'b1;
            end else ky_q <= ky_q + 1'b1;
          end else kx_q <= kx_q + 1'b1;
        end
        ST_WAIT: if (fin_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != ST_IDLE;
  assign clr_o      = (state_q == ST_IDLE) && start_i;
  assign wld_o      = state_q == ST_WLD;
  assign widx_o     = tap;
  assign wgt_addr_o = WA_W'(int'(ch_q) * NT + int'(tap));
  assign img_rd_o   = state_q == ST_CONV;
  assign img_addr_o = IA_W'(int'(ch_q) * IMG * IMG + (int'(oy_q) + int'(ky_q)) * IMG
                            + int'(ox_q) + int'(kx_q));
  assign tap_o      = tap;
  assign first_o    = tap == '0;
  assign last_o     = tap == TAP_W'(NT - 1);
  assign oy_o       = oy_q;
  assign ox_o       = ox_q;
  assign lch_o      = ch_end;

  // a start seen while busy must never re-enter the first weight fetch
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !(state_q == ST_WLD && ch_q == '0 && ky_q == '0 && kx_q == '0));
  assert_wgt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wld_o |-> (int'(wgt_addr_o) < CH * NT));
endmodule

// File: rtl/cpe_mac.sv
module cpe_mac #(
  parameter int IMG = 8,
  parameter int KS  = 3,
  parameter int DW  = 32,
  localparam int OUT   = IMG - KS + 1,
  localparam int NT    = KS * KS,
  localparam int OUT_W = cpe_pkg::wbits(OUT),
  localparam int TAP_W = cpe_pkg::wbits(NT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wld_i,
  input  logic [TAP_W-1:0] widx_i,
  input  logic [DW-1:0]    wgt_data_i,
  input  logic             rd_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [OUT_W-1:0] oy_i,
  input  logic [OUT_W-1:0] ox_i,
  input  logic             lch_i,
  input  logic [DW-1:0]    img_data_i,
  output logic             dot_v_o,
  output logic [DW-1:0]    dot_o,
  output logic [OUT_W-1:0] dot_oy_o,
  output logic [OUT_W-1:0] dot_ox_o,
  output logic             dot_lch_o
);
  logic [DW-1:0]    w_q [NT];
  logic             wv_q;
  logic [TAP_W-1:0] widx_q;
  logic             p_v, p_first, p_last, p_lch;
  logic [TAP_W-1:0] p_tap;
  logic [OUT_W-1:0] p_oy, p_ox;
  logic [DW-1:0]    sum_q, prod, sum_nxt;

  // align request-side tags with returning memory data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wv_q <= 1'b0; widx_q <= '0;
      p_v <= 1'b0; p_first <= 1'b0; p_last <= 1'b0; p_lch <= 1'b0;
      p_tap <= '0; p_oy <= '0; p_ox <= '0;
    end else begin
      wv_q <= wld_i; widx_q <= widx_i;
      p_v <= rd_i; p_first <= first_i; p_last <= last_i; p_lch <= lch_i;
      p_tap <= tap_i; p_oy <= oy_i; p_ox <= ox_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NT; i++) w_q[i] <= '0;
    end else if (wv_q) begin
      w_q[widx_q] <= wgt_data_i;
    end
  end

  assign prod    = img_data_i * w_q[p_tap];
  assign sum_nxt = p_first ? prod : sum_q + prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0; dot_v_o <= 1'b0; dot_o <= '0;
      dot_oy_o <= '0; dot_ox_o <= '0; dot_lch_o <= 1'b0;
    end else begin
      if (p_v) sum_q <= sum_nxt;
      dot_v_o <= p_v && p_last;
      if (p_v && p_last) begin
        dot_o     <= sum_nxt;
        dot_oy_o  <= p_oy;
        dot_ox_o  <= p_ox;
        dot_lch_o <= p_lch;
      end
    end
  end

  assert_one_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wld_i, rd_i}));
  assert_dot_timing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_v_o |-> $past(rd_i && last_i, 2));
endmodule

// File: rtl/cpe_accbuf.sv
module cpe_accbuf #(
  parameter int IMG = 8,
  parameter int KS  = 3,
  parameter int PS  = 2,
  parameter int DW  = 32,
  localparam int OUT   = IMG - KS + 1,
  localparam int PO    = OUT / PS,
  localparam int OUT_W = cpe_pkg::wbits(OUT),
  localparam int OA_W  = cpe_pkg::wbits(PO * PO)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             dot_v_i,
  input  logic [DW-1:0]    dot_i,
  input  logic [OUT_W-1:0] oy_i,
  input  logic [OUT_W-1:0] ox_i,
  input  logic             lch_i,
  output logic             out_we_o,
  output logic [OA_W-1:0]  out_addr_o,
  output logic [DW-1:0]    out_data_o,
  output logic             done_o
);
  logic [DW-1:0]   acc_q [OUT][OUT];
  logic [DW-1:0]   upd, pool_mx;
  logic            pool_pt;
  logic [OA_W-1:0] cnt_q;

  for (genvar r = 0; r < OUT; r++) begin : g_row
    for (genvar c = 0; c < OUT; c++) begin : g_col
      logic hit;
      assign hit = dot_v_i && oy_i == OUT_W'(r) && ox_i == OUT_W'(c);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  acc_q[r][c] <= '0;
        else if (clr_i) acc_q[r][c] <= '0;
        else if (hit) acc_q[r][c] <= acc_q[r][c] + dot_i;
      end
    end
  end

  assign upd     = acc_q[oy_i][ox_i] + dot_i;
  assign pool_pt = dot_v_i && lch_i && (int'(oy_i) % PS == PS - 1)
                   && (int'(ox_i) % PS == PS - 1);

  // window max with zero floor; the closing element bypasses its pending write
  always_comb begin
    int r, c;
    logic [DW-1:0] v;
    pool_mx = '0;
    for (int i = 0; i < PS; i++) begin
      for (int j = 0; j < PS; j++) begin
        r = (int'(oy_i) / PS) * PS + i;
        c = (int'(ox_i) / PS) * PS + j;
        v = (i == PS - 1 && j == PS - 1) ? upd : acc_q[r][c];
        if ($signed(v) > $signed(pool_mx)) pool_mx = v;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; out_we_o <= 1'b0; out_addr_o <= '0; out_data_o <= '0; done_o <= 1'b0;
    end else begin
      done_o <= out_we_o && out_addr_o == OA_W'(PO * PO - 1);
      if (clr_i) begin
        cnt_q    <= '0;
        out_we_o <= 1'b0;
      end else begin
        out_we_o <= pool_pt;
        if (pool_pt) begin
          out_data_o <= pool_mx;
          out_addr_o <= cnt_q;
          cnt_q      <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_out_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_o |-> (int'(out_addr_o) < PO * PO));
  assert_pool_lastch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_o |-> $past(dot_v_i && lch_i));
  assert_done_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(out_we_o));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/conv_pool_engine.sv
module conv_pool_engine #(
  parameter int CH  = 16,
  parameter int IMG = 8,
  parameter int KS  = 3,
  parameter int PS  = 2,
  parameter int DW  = 32,
  localparam int OUT   = IMG - KS + 1,
  localparam int NT    = KS * KS,
  localparam int PO    = OUT / PS,
  localparam int OUT_W = cpe_pkg::wbits(OUT),
  localparam int TAP_W = cpe_pkg::wbits(NT),
  localparam int IA_W  = cpe_pkg::wbits(CH * IMG * IMG),
  localparam int WA_W  = cpe_pkg::wbits(CH * NT),
  localparam int OA_W  = cpe_pkg::wbits(PO * PO)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            img_rd_o,
  output logic [IA_W-1:0] img_addr_o,
  input  logic [DW-1:0]   img_data_i,
  output logic            wgt_rd_o,
  output logic [WA_W-1:0] wgt_addr_o,
  input  logic [DW-1:0]   wgt_data_i,
  output logic            out_we_o,
  output logic [OA_W-1:0] out_addr_o,
  output logic [DW-1:0]   out_data_o
);
  logic             clr, first, last, lch;
  logic [TAP_W-1:0] widx, tap;
  logic [OUT_W-1:0] oy, ox;
  logic             dot_v, dot_lch;
  logic [DW-1:0]    dot;
  logic [OUT_W-1:0] dot_oy, dot_ox;

  cpe_ctrl #(.CH(CH), .IMG(IMG), .KS(KS)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .fin_i(done_o), .busy_o, .clr_o(clr),
    .wld_o(wgt_rd_o), .widx_o(widx), .wgt_addr_o,
    .img_rd_o, .img_addr_o, .tap_o(tap), .first_o(first), .last_o(last),
    .oy_o(oy), .ox_o(ox), .lch_o(lch)
  );

  cpe_mac #(.IMG(IMG), .KS(KS), .DW(DW)) u_mac (
    .clk_i, .rst_ni, .wld_i(wgt_rd_o), .widx_i(widx), .wgt_data_i,
    .rd_i(img_rd_o), .tap_i(tap), .first_i(first), .last_i(last),
    .oy_i(oy), .ox_i(ox), .lch_i(lch), .img_data_i,
    .dot_v_o(dot_v), .dot_o(dot), .dot_oy_o(dot_oy), .dot_ox_o(dot_ox), .dot_lch_o(dot_lch)
  );

  cpe_accbuf #(.IMG(IMG), .KS(KS), .PS(PS), .DW(DW)) u_acc (
    .clk_i, .rst_ni, .clr_i(clr), .dot_v_i(dot_v), .dot_i(dot),
    .oy_i(dot_oy), .ox_i(dot_ox), .lch_i(dot_lch),
    .out_we_o, .out_addr_o, .out_data_o, .done_o
  );

  assert_we_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_o |-> busy_o);
endmodule

// File: tb/conv_pool_engine_tb_top.sv
`timescale 1ns/1ps
module conv_pool_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        busy_o, done_o, img_rd_o, wgt_rd_o, out_we_o;
  logic [9:0]  img_addr_o;
  logic [7:0]  wgt_addr_o;
  logic [3:0]  out_addr_o;
  logic [31:0] img_data_i = '0, wgt_data_i = '0, out_data_o;

  always #4 clk_i = ~clk_i;

  conv_pool_engine dut_i (
    .clk_i, .rst_ni, .start_i, .busy_o, .done_o,
    .img_rd_o, .img_addr_o, .img_data_i,
    .wgt_rd_o, .wgt_addr_o, .wgt_data_i,
    .out_we_o, .out_addr_o, .out_data_o
  );

  int img_mem [1024];
  int wgt_mem [144];

  always @(posedge clk_i) begin
    if (img_rd_o) img_data_i <= img_mem[img_addr_o];
    if (wgt_rd_o) wgt_data_i <= wgt_mem[wgt_addr_o];
  end

  typedef struct { int addr; int data; } exp_t;
  exp_t  exp_q[$];
  string cur_tag = "";
  int    total = 0, fails = 0;
  int    rd_img, rd_wgt, rd_last, wr_cnt, first_rd_last, ref_len = 0;
  bit    prev_last = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // golden model: wrapping 32-bit int arithmetic, zero-floored 2x2 max
  task automatic push_expected();
    int cv [6][6];
    int mx, v;
    for (int oy = 0; oy < 6; oy++)
      for (int ox = 0; ox < 6; ox++) begin
        cv[oy][ox] = 0;
        for (int c = 0; c < 16; c++)
          for (int ky = 0; ky < 3; ky++)
            for (int kx = 0; kx < 3; kx++)
              cv[oy][ox] += img_mem[64*c + 8*(oy+ky) + ox + kx] * wgt_mem[9*c + 3*ky + kx];
      end
    for (int py = 0; py < 3; py++)
      for (int px = 0; px < 3; px++) begin
        mx = 0;
        for (int i = 0; i < 2; i++)
          for (int j = 0; j < 2; j++) begin
            v = cv[2*py+i][2*px+j];
            if (v > mx) mx = v;
          end
        exp_q.push_back('{addr: py*3 + px, data: mx});
      end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (img_rd_o) begin
        rd_img++;
        if (img_addr_o >= 10'd960) rd_last++;
      end
      if (wgt_rd_o) rd_wgt++;
      if (out_we_o) begin
        exp_t e;
        if (wr_cnt == 0) first_rd_last = rd_last;
        wr_cnt++;
        check(busy_o, "R6", "write while busy", int'(busy_o), 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected write", int'(out_addr_o), -1);
        end else begin
          e = exp_q.pop_front();
          check(int'(out_addr_o) == e.addr, "R6", "write order", int'(out_addr_o), e.addr);
          check(int'(out_data_o) == e.data, cur_tag, "pooled word", int'(out_data_o), e.data);
        end
      end
      if (done_o) check(prev_last, "R8", "done after ninth write", int'(prev_last), 1);
      prev_last = out_we_o && out_addr_o == 4'd8;
    end
  end

  task automatic run_case(input string tag, input bit poke);
    int cyc;
    cur_tag = tag;
    push_expected();
    @(posedge clk_i);
    rd_img = 0; rd_wgt = 0; rd_last = 0; wr_cnt = 0; first_rd_last = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk_i);
      cyc++;
      start_i = (poke && (cyc == 300 || cyc == 3000)) ? 1'b1 : 1'b0;
    end while (!done_o && cyc < 8000);
    start_i = 1'b0;
    check(done_o, "R8", "done reached", int'(done_o), 1);
    if (ref_len == 0) ref_len = cyc;
    else check(cyc == ref_len, "R9", "run length", cyc, ref_len);
    @(negedge clk_i);
    check(!done_o, "R8", "done one cycle", int'(done_o), 0);
    check(!busy_o, "R8", "busy low after done", int'(busy_o), 0);
    check(wr_cnt == 9, "R6", "write count", wr_cnt, 9);
    check(exp_q.size() == 0, "R6", "pending expected", exp_q.size(), 0);
    check(rd_img == 5184, "R2", "image reads", rd_img, 5184);
    check(rd_wgt == 144, "R3", "weight reads", rd_wgt, 144);
    check(first_rd_last > 0 && first_rd_last < 324, "R7",
          "last-channel reads before first write", first_rd_last, 1);
    exp_q.delete();
  endtask

  initial begin
    int seed;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !out_we_o && !img_rd_o && !wgt_rd_o, "R1",
          "outputs in reset", int'({busy_o, done_o, out_we_o, img_rd_o, wgt_rd_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !out_we_o && !img_rd_o && !wgt_rd_o, "R1",
          "idle after reset", int'({busy_o, done_o, out_we_o, img_rd_o, wgt_rd_o}), 0);

    // R4: uniform ones
    foreach (img_mem[i]) img_mem[i] = 1;
    foreach (wgt_mem[i]) wgt_mem[i] = 1;
    run_case("R4", 1'b0);

    // R2 R3: ramped image, cycling weights
    foreach (img_mem[i]) img_mem[i] = i % 128;
    foreach (wgt_mem[i]) wgt_mem[i] = i % 3;
    run_case("R2", 1'b0);

    // R5: channel 0 horizontal ramp, centre tap only -> mixed signs
    foreach (img_mem[i]) img_mem[i] = (i < 64) ? (i % 8) - 4 : 0;
    foreach (wgt_mem[i]) wgt_mem[i] = (i == 4) ? 1 : 0;
    run_case("R5", 1'b0);

    // R5: every window negative
    foreach (img_mem[i]) img_mem[i] = 1;
    foreach (wgt_mem[i]) wgt_mem[i] = -1;
    run_case("R5", 1'b0);

    // R10: large operands wrap
    foreach (img_mem[i]) img_mem[i] = 32'h0FFF_FFFF + i;
    foreach (wgt_mem[i]) wgt_mem[i] = 3 + (i % 5);
    run_case("R10", 1'b0);

    // R9: pseudo-random signed data with stray starts, then R11: rerun
    seed = 7;
    foreach (img_mem[i]) begin seed = seed * 1103515245 + 12345; img_mem[i] = ((seed >> 16) & 15) - 8; end
    foreach (wgt_mem[i]) begin seed = seed * 1103515245 + 12345; wgt_mem[i] = ((seed >> 16) & 15) - 7; end
    run_case("R9", 1'b1);
    run_case("R11", 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule